// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache placed between a processor load/store port and a slower, word-wide main memory. It keeps 1024 lines of four 32-bit words (16 KB). Each line has a stored tag and a valid flag. A write-back build also keeps a dirty flag per line. Each 32-bit byte address is split into tag, line index and offset. The indexed line is checked, and the addressed word is returned on a hit. On a miss the controller fetches a whole line from memory as a burst of four single-word transfers.

Two parameters choose how stores are handled. `WRITE_BACK` selects write-back with dirty tracking or write-through. `WRITE_ALLOC` selects whether a store miss first fills the line or goes straight to memory past the cache. The processor issues one request at a time: it holds `cpu_req` until the cycle in which `cpu_ready` is high, then waits until `cpu_ready` rises again. A load's data comes with a one-cycle `cpu_rdata_valid` pulse. On the memory side each word is a request held until `mem_ack`.

Top module: `dcache_ctrl`

## Requirements
- R1: A byte address is decoded as tag = bits [31:14], line index = bits [13:4], byte offset = bits [3:0]. Bits [3:2] select the word inside a line. Two addresses with the same index but different tags never hit on each other's line.
- R2: After reset `cpu_ready` is 1, `cpu_rdata_valid` is 0, `mem_req` is 0 and every line is invalid, so the first access to any line is a miss.
- R3: A hit requires the indexed line to be valid with a stored tag equal to the address tag. A load hit raises `cpu_rdata_valid` for exactly one cycle, in the cycle after the request is accepted, with the addressed word and no memory traffic.
- R4: A load miss reads the four words of the line from memory in ascending order, starting at the line base address. Each word is a request held stable until `mem_ack`. The line then becomes valid with the new tag, and the addressed word is returned.
- R5: A miss on a valid line holding another tag replaces that line. The old contents are no longer returned by the cache.
- R6: Write-through (`WRITE_BACK`=0): a store hit updates only the addressed word in the line and issues exactly one memory write of that word.
- R7: Write-back (`WRITE_BACK`=1): a store hit updates only the cache and marks the line dirty, with no memory traffic.
- R8: Write-back: when a line is replaced, it is first written to memory as four ascending word writes, but only if it is dirty. A clean line is replaced with no memory writes. Write-through never writes a line back on replacement.
- R9: Write-allocate (`WRITE_ALLOC`=1): a store miss fetches the full line and then changes only the addressed word. The other words keep their memory values.
- R10: Write-around (`WRITE_ALLOC`=0): a store miss performs one memory write and leaves the cache unchanged, so a later load of that address misses and returns the stored value from memory.
- R11: Once a request is accepted, `cpu_ready` stays low until the whole operation, including any burst or memory write, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Controller idle; a request is accepted in this cycle |
| cpu_rdata | output | 32 | Load data |
| cpu_rdata_valid | output | 1 | One-cycle pulse qualifying `cpu_rdata` |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Two builds run side by side: write-back with allocate, and write-through with write-around. The bench targets the conflict between two tags on one index. A controller that skips the dirty write-back loses a stored word. One that writes back clean lines shows extra memory writes. A tag comparison that ignores upper tag bits returns the wrong line's data. A burst with wrong order or base puts words in the wrong slots, which the read-address log and the returned words expose. A write-around that allocates anyway, or a write-through that skips the memory write, is caught by counting memory reads and writes and by reading the address back afterwards.

// File: rtl/dcache_pkg.sv
// Shared types for the direct-mapped data cache.
// Assumes: a single in-flight processor request; state encoding is internal.
package dcache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_MEMWR
    } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
// Per-line valid, dirty and tag storage with the hit comparator.
// Assumes: LINES == 2**IDX_W; fill and mark_dirty are never active together.
module dcache_tag_store #(
    parameter int LINES = 1024,
    parameter int IDX_W = 10,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             fill,
    input  logic             mark_dirty,
    output logic             hit,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Clear all flags at reset; a fill validates a clean line, a store hit dirties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Record the tag of a freshly filled line.
    always_ff @(posedge clk) begin
        if (fill) tag_q[idx] <= tag;
    end

    // Look up the indexed line and compare the tags.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
        hit        = line_valid && (line_tag == tag);
    end
endmodule

// File: rtl/dcache_data_store.sv
// Line data storage: one packed line per entry, written and read one word at a time.
// Assumes: LINES == 2**IDX_W and LINE_WORDS == 2**WSEL_W.
module dcache_data_store #(
    parameter int LINES      = 1024,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 10,
    parameter int WSEL_W     = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WSEL_W-1:0] rsel,
    output logic [DATA_W-1:0] rdata
);
    logic [LINE_WORDS-1:0][DATA_W-1:0] line_q [LINES];

    // Write a single word of the indexed line.
    always_ff @(posedge clk) begin
        if (we) line_q[idx][wsel] <= wdata;
    end

    // Read a single word of the indexed line.
    always_comb rdata = line_q[idx][rsel];
endmodule

// File: rtl/dcache_fsm.sv
// Controller sequencing lookup, dirty write-back, line refill and single-word memory writes.
// Assumes: hit/line flags reflect the latched request address; mem_ack is only seen while mem_req is high.
module dcache_fsm
    import dcache_pkg::*;
#(
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1,
    parameter int LINE_WORDS  = 4,
    parameter int WSEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              req_we,
    input  logic              hit,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic              mem_ack,
    output dc_state_e         state,
    output logic [WSEL_W-1:0] cnt,
    output logic              accept,
    output logic              cpu_ready,
    output logic              rdata_valid,
    output logic              data_we,
    output logic              fill_done,
    output logic              mark_dirty,
    output logic              mem_req,
    output logic              mem_we
);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

    dc_state_e state_d;
    logic      burst_last;
    logic      store_hit;

    // Decode the per-state outputs.
    always_comb begin
        cpu_ready   = (state == ST_IDLE);
        accept      = cpu_ready && cpu_req;
        burst_last  = mem_ack && (cnt == LAST_WORD);
        store_hit   = (state == ST_COMPARE) && hit && req_we;
        rdata_valid = (state == ST_COMPARE) && hit && !req_we;
        mark_dirty  = store_hit && WRITE_BACK;
        fill_done   = (state == ST_REFILL) && burst_last;
        data_we     = store_hit || ((state == ST_REFILL) && mem_ack);
        mem_req     = (state == ST_WRITEBACK) || (state == ST_REFILL) || (state == ST_MEMWR);
        mem_we      = (state == ST_WRITEBACK) || (state == ST_MEMWR);
    end

    // Choose the next state from the lookup result and burst progress.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (hit)
                    state_d = (req_we && !WRITE_BACK) ? ST_MEMWR : ST_IDLE;
                else if (req_we && !WRITE_ALLOC)
                    state_d = ST_MEMWR;
                else if (WRITE_BACK && line_valid && line_dirty)
                    state_d = ST_WRITEBACK;
                else
                    state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (burst_last) state_d = ST_REFILL;
            ST_REFILL:    if (burst_last) state_d = ST_COMPARE;
            ST_MEMWR:     if (mem_ack) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and burst word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            if ((state == ST_WRITEBACK || state == ST_REFILL) && mem_ack)
                cnt <= burst_last ? '0 : cnt + 1'b1;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid); // R3
    AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> !cpu_ready); // R11
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_WRITEBACK) |-> $past(line_dirty)); // R8
endmodule

// File: rtl/dcache_ctrl.sv
// Top of the direct-mapped data cache: request latch, address decode, memory address/data muxes.
// Assumes: word-aligned processor addresses; one request outstanding at a time.
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int LINES       = 1024,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdata_valid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BSEL_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BSEL_W + WSEL_W;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic [ADDR_W-1:0] req_addr;
    logic              req_we;
    logic [DATA_W-1:0] req_wdata;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_wsel;
    dc_state_e         state;
    logic [WSEL_W-1:0] cnt;
    logic              accept, hit, line_valid, line_dirty;
    logic              data_we, fill_done, mark_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [WSEL_W-1:0] d_wsel, d_rsel;
    logic [DATA_W-1:0] d_wdata, d_rdata;

    // Latch the processor request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_we    <= 1'b0;
            req_wdata <= '0;
        end else if (accept) begin
            req_addr  <= cpu_addr;
            req_we    <= cpu_we;
            req_wdata <= cpu_wdata;
        end
    end

    // Split the latched address into its fields.
    always_comb begin
        req_tag  = req_addr[ADDR_W-1 -: TAG_W];
        req_idx  = req_addr[OFF_W +: IDX_W];
        req_wsel = req_addr[BSEL_W +: WSEL_W];
    end

    // Steer the data store and the memory port according to the current state.
    always_comb begin
        d_wsel    = (state == ST_REFILL) ? cnt : req_wsel;
        d_rsel    = (state == ST_WRITEBACK) ? cnt : req_wsel;
        d_wdata   = (state == ST_REFILL) ? mem_rdata : req_wdata;
        mem_wdata = (state == ST_WRITEBACK) ? d_rdata : req_wdata;
        cpu_rdata = d_rdata;
        case (state)
            ST_WRITEBACK: mem_addr = {line_tag, req_idx, cnt, {BSEL_W{1'b0}}};
            ST_REFILL:    mem_addr = {req_tag, req_idx, cnt, {BSEL_W{1'b0}}};
            default:      mem_addr = req_addr;
        endcase
    end

    dcache_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(req_idx), .tag(req_tag),
        .fill(fill_done), .mark_dirty(mark_dirty), .hit(hit),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag)
    );

    dcache_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
                        .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
        .clk(clk), .idx(req_idx), .we(data_we), .wsel(d_wsel), .wdata(d_wdata),
        .rsel(d_rsel), .rdata(d_rdata)
    );

    dcache_fsm #(.WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC),
                 .LINE_WORDS(LINE_WORDS), .WSEL_W(WSEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .req_we(req_we), .hit(hit),
        .line_valid(line_valid), .line_dirty(line_dirty), .mem_ack(mem_ack),
        .state(state), .cnt(cnt), .accept(accept), .cpu_ready(cpu_ready),
        .rdata_valid(cpu_rdata_valid), .data_we(data_we), .fill_done(fill_done),
        .mark_dirty(mark_dirty), .mem_req(mem_req), .mem_we(mem_we)
    );

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4
    AST_FILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> hit); // R4
endmodule

// File: tb/sim_dcache_ctrl.sv
// Directed bench: u0 is write-back + allocate, u1 is write-through + write-around.
module sim_dcache_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [1:0]  cpu_req, cpu_we, cpu_ready, cpu_rdata_valid, mem_req, mem_we, mem_ack;
    logic [31:0] cpu_addr [2];
    logic [31:0] cpu_wdata [2];
    logic [31:0] cpu_rdata [2];
    logic [31:0] mem_addr [2];
    logic [31:0] mem_wdata [2];
    logic [31:0] mem_rdata [2];

    int n_chk = 0;
    int n_fail = 0;

    dcache_ctrl #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
        .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
        .cpu_rdata(cpu_rdata[0]), .cpu_rdata_valid(cpu_rdata_valid[0]),
        .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
        .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

    dcache_ctrl #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
        .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
        .cpu_rdata(cpu_rdata[1]), .cpu_rdata_valid(cpu_rdata_valid[1]),
        .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
        .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

    // Memory model: only addresses with bits [13:6] zero and below 0x10000 are used.
    logic [31:0] bmem [2][64];
    logic [31:0] rd_log [2][4];
    int rd_cnt [2];
    int wr_cnt [2];

    function automatic int key(input logic [31:0] a);
        return int'({a[15:14], a[5:2]});
    endfunction

    function automatic logic [31:0] init_val(input int k);
        return 32'hC0DE_0000 | 32'(k);
    endfunction

    // Answer each memory word request after one cycle; log reads, count writes.
    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                mem_ack[d] <= 1'b0;
                mem_rdata[d] <= '0;
                rd_cnt[d] <= 0;
                wr_cnt[d] <= 0;
                for (int k = 0; k < 64; k++) bmem[d][k] <= init_val(k);
            end else if (mem_req[d] && !mem_ack[d]) begin
                mem_ack[d] <= 1'b1;
                if (mem_we[d]) begin
                    bmem[d][key(mem_addr[d])] <= mem_wdata[d];
                    wr_cnt[d] <= wr_cnt[d] + 1;
                end else begin
                    mem_rdata[d] <= bmem[d][key(mem_addr[d])];
                    rd_log[d][rd_cnt[d] % 4] <= mem_addr[d];
                    rd_cnt[d] <= rd_cnt[d] + 1;
                end
            end else begin
                mem_ack[d] <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One processor access; returns data, cycles until ready, valid-pulse count and hit-timing flag.
    task automatic access(input int d, input logic [31:0] a, input logic w, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat, output int nvalid,
                          output logic first_valid);
        @(negedge clk);
        cpu_req[d] = 1'b1; cpu_addr[d] = a; cpu_we[d] = w; cpu_wdata[d] = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req[d] = 1'b0;
        lat = 1; nvalid = 0; rd = '0;
        first_valid = cpu_rdata_valid[d];
        while (!cpu_ready[d] && lat < 2000) begin
            if (cpu_rdata_valid[d]) begin nvalid++; rd = cpu_rdata[d]; end
            @(negedge clk);
            lat++;
        end
        if (lat >= 2000) chk("R11 access timeout", 32'(lat), 32'd0);
    endtask

    logic [31:0] rd;
    int lat, nv, r0, w0;
    logic fv;

    task automatic t_reset();
        @(negedge clk);
        chk("R2 ready after reset", {30'd0, cpu_ready}, 32'd3);
        chk("R2 no valid after reset", {30'd0, cpu_rdata_valid}, 32'd0);
        chk("R2 no mem_req after reset", {30'd0, mem_req}, 32'd0);
    endtask

    task automatic t_cold_read();
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 32'h14, 1'b0, 0, rd, lat, nv, fv);
        chk("R2 first access misses", {31'd0, fv}, 32'd0);
        chk("R4 fill data word1", rd, init_val(5));
        chk("R4 one valid pulse", 32'(nv), 32'd1);
        chk("R4 four reads", 32'(rd_cnt[0] - r0), 32'd4);
        chk("R4 no writes", 32'(wr_cnt[0] - w0), 32'd0);
        chk("R4 burst word0 addr", rd_log[0][0], 32'h10);
        chk("R4 burst word3 addr", rd_log[0][3], 32'h1C);
    endtask

    task automatic t_read_hit();
        r0 = rd_cnt[0];
        access(0, 32'h1C, 1'b0, 0, rd, lat, nv, fv);
        chk("R3 hit data", rd, init_val(7));
        chk("R3 valid in cycle after accept", {31'd0, fv}, 32'd1);
        chk("R3 exactly one valid cycle", 32'(nv), 32'd1);
        chk("R11 hit latency", 32'(lat), 32'd2);
        chk("R3 hit no memory read", 32'(rd_cnt[0] - r0), 32'd0);
    endtask

    task automatic t_wb_write_hit();
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 32'h18, 1'b1, 32'hDEAD_0018, rd, lat, nv, fv);
        chk("R7 store hit no memory write", 32'(wr_cnt[0] - w0), 32'd0);
        chk("R7 store hit no memory read", 32'(rd_cnt[0] - r0), 32'd0);
        chk("R7 store hit latency", 32'(lat), 32'd2);
        chk("R7 store hit no valid", 32'(nv), 32'd0);
        access(0, 32'h18, 1'b0, 0, rd, lat, nv, fv);
        chk("R7 cached value", rd, 32'hDEAD_0018);
        chk("R7 readback hits", {31'd0, fv}, 32'd1);
        chk("R7 memory still stale", bmem[0][6], init_val(6));
    endtask

    task automatic t_dirty_evict();
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 32'h4014, 1'b0, 0, rd, lat, nv, fv);
        chk("R8 dirty line written back", 32'(wr_cnt[0] - w0), 32'd4);
        chk("R8 stored word reached memory", bmem[0][6], 32'hDEAD_0018);
        chk("R8 untouched word written back intact", bmem[0][4], init_val(4));
        chk("R5 new line data", rd, init_val(21));
        chk("R4 new tag fill reads", 32'(rd_cnt[0] - r0), 32'd4);
        chk("R4 refill base", rd_log[0][0], 32'h4010);
        chk("R4 refill last", rd_log[0][3], 32'h401C);
    endtask

    task automatic t_clean_evict();
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 32'h18, 1'b0, 0, rd, lat, nv, fv);
        chk("R5 replaced line misses", {31'd0, fv}, 32'd0);
        chk("R8 clean line not written", 32'(wr_cnt[0] - w0), 32'd0);
        chk("R5 data refetched", rd, 32'hDEAD_0018);
        chk("R5 refill reads", 32'(rd_cnt[0] - r0), 32'd4);
    endtask

    task automatic t_tag_bits();
        access(0, 32'h8014, 1'b0, 0, rd, lat, nv, fv);
        chk("R1 upper tag bit distinguishes line", {31'd0, fv}, 32'd0);
        chk("R1 tag2 data", rd, init_val(37));
        access(0, 32'h8018, 1'b0, 0, rd, lat, nv, fv);
        chk("R1 word select bits [3:2]", rd, init_val(38));
        chk("R1 same line hits", {31'd0, fv}, 32'd1);
    endtask

    task automatic t_write_alloc();
        r0 = rd_cnt[0]; w0 = wr_cnt[0];
        access(0, 32'h24, 1'b1, 32'hBEEF_0024, rd, lat, nv, fv);
        chk("R9 allocate reads line", 32'(rd_cnt[0] - r0), 32'd4);
        chk("R9 allocate no memory write", 32'(wr_cnt[0] - w0), 32'd0);
        access(0, 32'h24, 1'b0, 0, rd, lat, nv, fv);
        chk("R9 stored word in line", rd, 32'hBEEF_0024);
        chk("R9 readback hits", {31'd0, fv}, 32'd1);
        access(0, 32'h20, 1'b0, 0, rd, lat, nv, fv);
        chk("R9 neighbour word from memory", rd, init_val(8));
    endtask

    task automatic t_write_around();
        r0 = rd_cnt[1]; w0 = wr_cnt[1];
        access(1, 32'h34, 1'b1, 32'h5A5A_0034, rd, lat, nv, fv);
        chk("R10 one memory write", 32'(wr_cnt[1] - w0), 32'd1);
        chk("R10 no line fill", 32'(rd_cnt[1] - r0), 32'd0);
        chk("R10 memory updated", bmem[1][13], 32'h5A5A_0034);
        r0 = rd_cnt[1];
        access(1, 32'h34, 1'b0, 0, rd, lat, nv, fv);
        chk("R10 cache left unchanged (miss)", {31'd0, fv}, 32'd0);
        chk("R10 miss reads line", 32'(rd_cnt[1] - r0), 32'd4);
        chk("R10 value from memory", rd, 32'h5A5A_0034);
    endtask

    task automatic t_wt_write_hit();
        r0 = rd_cnt[1]; w0 = wr_cnt[1];
        access(1, 32'h30, 1'b1, 32'h1234_0030, rd, lat, nv, fv);
        chk("R6 one memory write", 32'(wr_cnt[1] - w0), 32'd1);
        chk("R6 no memory read", 32'(rd_cnt[1] - r0), 32'd0);
        chk("R6 memory word updated", bmem[1][12], 32'h1234_0030);
        access(1, 32'h30, 1'b0, 0, rd, lat, nv, fv);
        chk("R6 cache word updated", rd, 32'h1234_0030);
        chk("R6 readback hits", {31'd0, fv}, 32'd1);
        access(1, 32'h34, 1'b0, 0, rd, lat, nv, fv);
        chk("R6 other word untouched", rd, 32'h5A5A_0034);
    endtask

    task automatic t_wt_evict();
        r0 = rd_cnt[1]; w0 = wr_cnt[1];
        access(1, 32'h4034, 1'b0, 0, rd, lat, nv, fv);
        chk("R8 write-through no write-back", 32'(wr_cnt[1] - w0), 32'd0);
        chk("R5 write-through replace reads", 32'(rd_cnt[1] - r0), 32'd4);
        chk("R5 write-through new data", rd, init_val(29));
    endtask

    initial begin
        cpu_req = '0; cpu_we = '0;
        for (int d = 0; d < 2; d++) begin cpu_addr[d] = '0; cpu_wdata[d] = '0; end
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_read();
        t_read_hit();
        t_wb_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_tag_bits();
        t_write_alloc();
        t_write_around();
        t_wt_write_hit();
        t_wt_evict();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule